// File: doc/BRIEF.md
# Combining Fetch-and-Add Unit

This block is a shared file of global counter registers that many thread control units (TCUs) reach through their own request ports. In any cycle, each port may overwrite a register, read it, or ask for an atomic fetch-and-add. A fetch-and-add returns the register's value from before the add, and the register then advances by the increment.

Several fetch-and-add requests may name the same register in the same cycle. The unit does not queue them. It merges them in a single step: each requester receives its own prefix of the combined increments, and the register advances once by their total. Threads use this to claim distinct slots or identifiers by adding 1. They can also add arbitrary amounts, such as partial sums, into a shared accumulator.

Each accepted request is answered on the same port exactly one cycle later.

Top module: `psu_top`

## Requirements
- R1: While reset is active (synchronous, active low), every global register becomes 0 and every response valid bit becomes 0.
- R2: Port i takes its opcode from req_op[2i+1:2i]. The codes are 2'b00 read, 2'b01 set and 2'b10 fetch-and-add. Code 2'b11 is ignored: it gives no response and changes no register.
- R3: Port i is answered one cycle after its request. In that cycle rsp_valid[i] is 1 exactly when the port sent a request with a code other than 2'b11.
- R4: Port i takes its register index from req_idx[3i+2:3i]. A read returns the register's value from before any change made in the same cycle.
- R5: Port i takes its operand from req_data[32i+31:32i]. A single fetch-and-add returns the register's old value, and the register becomes old value plus operand.
- R6: Several fetch-and-adds may name one register in the same cycle. They are ordered by ascending port number. Each requester receives the starting value plus the operands of all lower-numbered requesters to that register. The register advances by the sum of all their operands.
- R7: Requests to different registers in the same cycle do not affect each other.
- R8: A set writes its operand into the register and returns the register's old value. When several sets name one register in a cycle, the lowest-numbered port's operand is written.
- R9: When a set and fetch-and-adds name the same register in one cycle, the fetch-and-adds start from the newly set value.
- R10: All additions wrap modulo 2^32.
- R11: When every port adds 1 to one register in a cycle, the ports receive consecutive, distinct values. Port 0 receives the lowest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 8 | Per-port request strobe |
| req_op | input | 16 | Per-port opcode, 2 bits per port |
| req_idx | input | 24 | Per-port register index, 3 bits per port |
| req_data | input | 256 | Per-port set value or increment, 32 bits per port |
| rsp_valid | output | 8 | Per-port response strobe |
| rsp_data | output | 256 | Per-port returned value, 32 bits per port |

## Verification
Directed cycles cover four distinct cases:
- All ports adding 1 to one register separates true combining from serialised or duplicated answers.
- A set mixed with adds on the same register shows whether the set is applied before or after the adds.
- Adds near 2^32 expose wrap handling.
- Adds spread over separate registers show whether lanes leak into each other.

Random cycles then crowd requests onto three registers with mixed opcodes, including the ignored code. This tests port ordering and read-before-write under heavy collisions, and follow-up reads confirm the register state.

// File: rtl/psu_pkg.sv
// Shared opcode type for the combining fetch-and-add unit.
package psu_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_SET  = 2'b01,
        OP_ADD  = 2'b10,
        OP_NONE = 2'b11
    } psu_op_e;

endpackage

// File: rtl/psu_port_decode.sv
// Decodes each port's request into one-hot intent flags.
// Assumes: opcodes follow psu_pkg::psu_op_e; OP_NONE requests are not accepted.
module psu_port_decode #(
    parameter int NUM_PORTS = 8
) (
    input  logic [NUM_PORTS-1:0]   req_valid,
    input  logic [2*NUM_PORTS-1:0] req_op,
    output logic [NUM_PORTS-1:0]   accept,
    output logic [NUM_PORTS-1:0]   is_set,
    output logic [NUM_PORTS-1:0]   is_add
);
    import psu_pkg::*;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        psu_op_e op_p;
        // Per-port opcode classification
        always_comb begin
            op_p      = psu_op_e'(req_op[2*p +: 2]);
            accept[p] = req_valid[p] && (op_p != OP_NONE);
            is_set[p] = req_valid[p] && (op_p == OP_SET);
            is_add[p] = req_valid[p] && (op_p == OP_ADD);
        end
    end

endmodule

// File: rtl/psu_lane.sv
// One register lane: gathers the requests aimed at register LANE_ID,
// picks the winning set (lowest port), and forms exclusive prefix sums
// of the increments in ascending port order.
// Assumes: increments of non-matching ports contribute zero.
module psu_lane #(
    parameter int NUM_PORTS = 8,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 3,
    parameter int LANE_ID   = 0
) (
    input  logic [NUM_PORTS-1:0]        is_set,
    input  logic [NUM_PORTS-1:0]        is_add,
    input  logic [IDX_W*NUM_PORTS-1:0]  req_idx,
    input  logic [DATA_W*NUM_PORTS-1:0] req_data,
    input  logic [DATA_W-1:0]           cur_val,
    output logic [DATA_W-1:0]           base_val,
    output logic [DATA_W*NUM_PORTS-1:0] prefix_flat,
    output logic                        wr_en,
    output logic [DATA_W-1:0]           wr_val
);
    logic [NUM_PORTS-1:0]             hit_set;
    logic [NUM_PORTS-1:0]             hit_add;
    logic                             set_any;
    logic [DATA_W-1:0]                set_val;
    logic [NUM_PORTS:0][DATA_W-1:0]   chain;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        // Match each port's index against this lane
        always_comb begin
            hit_set[p] = is_set[p] && (req_idx[IDX_W*p +: IDX_W] == IDX_W'(LANE_ID));
            hit_add[p] = is_add[p] && (req_idx[IDX_W*p +: IDX_W] == IDX_W'(LANE_ID));
        end
    end

    // Lowest-numbered set wins: scan downward so the last assignment is port 0
    always_comb begin
        set_any = 1'b0;
        set_val = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (hit_set[p]) begin
                set_any = 1'b1;
                set_val = req_data[DATA_W*p +: DATA_W];
            end
        end
    end

    // Starting point for this cycle's increments
    always_comb base_val = set_any ? set_val : cur_val;

    assign chain[0] = '0;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chain
        // Ripple accumulation of matching increments in port order
        always_comb begin
            chain[p+1] = chain[p] + (hit_add[p] ? req_data[DATA_W*p +: DATA_W] : '0);
            prefix_flat[DATA_W*p +: DATA_W] = chain[p];
        end
    end

    // Register update request
    always_comb begin
        wr_en  = set_any || (|hit_add);
        wr_val = base_val + chain[NUM_PORTS];
    end

endmodule

// File: rtl/psu_regfile.sv
// Global register file with one write per register per cycle.
// Assumes: the lanes already merged all writers of a register.
module psu_regfile #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        wr_en,
    input  logic [DATA_W*NUM_REGS-1:0] wr_flat,
    output logic [DATA_W*NUM_REGS-1:0] rd_flat
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic [DATA_W-1:0] val_q;
        // Storage for one global register
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (wr_en[r])
                val_q <= wr_flat[DATA_W*r +: DATA_W];
        end
        assign rd_flat[DATA_W*r +: DATA_W] = val_q;
    end

endmodule

// File: rtl/psu_top.sv
// Combining fetch-and-add unit: NUM_PORTS requesters share NUM_REGS global
// registers. Same-cycle adds to one register are merged with per-port
// prefixes; every accepted request is answered one cycle later.
// Assumes: requesters hold no outstanding state; responses are not back-pressured.
module psu_top #(
    parameter int NUM_PORTS = 8,
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [2*NUM_PORTS-1:0]      req_op,
    input  logic [IDX_W*NUM_PORTS-1:0]  req_idx,
    input  logic [DATA_W*NUM_PORTS-1:0] req_data,
    output logic [NUM_PORTS-1:0]        rsp_valid,
    output logic [DATA_W*NUM_PORTS-1:0] rsp_data
);
    logic [NUM_PORTS-1:0]        accept;
    logic [NUM_PORTS-1:0]        is_set;
    logic [NUM_PORTS-1:0]        is_add;
    logic [DATA_W*NUM_REGS-1:0]  reg_flat;
    logic [DATA_W*NUM_REGS-1:0]  wr_flat;
    logic [NUM_REGS-1:0]         wr_en;
    logic [DATA_W-1:0]           lane_base [NUM_REGS];
    logic [DATA_W*NUM_PORTS-1:0] lane_pre  [NUM_REGS];
    logic [DATA_W*NUM_PORTS-1:0] rsp_next;

    psu_port_decode #(.NUM_PORTS(NUM_PORTS)) u_decode (
        .req_valid (req_valid),
        .req_op    (req_op),
        .accept    (accept),
        .is_set    (is_set),
        .is_add    (is_add)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_lane
        psu_lane #(
            .NUM_PORTS (NUM_PORTS),
            .DATA_W    (DATA_W),
            .IDX_W     (IDX_W),
            .LANE_ID   (r)
        ) u_lane (
            .is_set      (is_set),
            .is_add      (is_add),
            .req_idx     (req_idx),
            .req_data    (req_data),
            .cur_val     (reg_flat[DATA_W*r +: DATA_W]),
            .base_val    (lane_base[r]),
            .prefix_flat (lane_pre[r]),
            .wr_en       (wr_en[r]),
            .wr_val      (wr_flat[DATA_W*r +: DATA_W])
        );
    end

    psu_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_flat (wr_flat),
        .rd_flat (reg_flat)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
        logic [IDX_W-1:0]  sel;
        logic [DATA_W-1:0] add_val;
        // Choose the answer: prefix result for adds, pre-cycle value otherwise
        always_comb begin
            sel     = req_idx[IDX_W*p +: IDX_W];
            add_val = lane_base[sel] + lane_pre[sel][DATA_W*p +: DATA_W];
            rsp_next[DATA_W*p +: DATA_W] = is_add[p] ? add_val
                                                     : reg_flat[DATA_W*sel +: DATA_W];
        end

        // One-cycle response register per port
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsp_valid[p]                  <= 1'b0;
                rsp_data[DATA_W*p +: DATA_W]  <= '0;
            end else begin
                rsp_valid[p] <= accept[p];
                if (accept[p])
                    rsp_data[DATA_W*p +: DATA_W] <= rsp_next[DATA_W*p +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/psu_checker.sv
// Property checker for psu_top, attached by bind. Observes the ports and
// the register file outputs; builds its own per-register summaries.
module psu_checker #(
    parameter int NUM_PORTS = 8,
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_PORTS-1:0]        req_valid,
    input logic [2*NUM_PORTS-1:0]      req_op,
    input logic [IDX_W*NUM_PORTS-1:0]  req_idx,
    input logic [DATA_W*NUM_PORTS-1:0] req_data,
    input logic [NUM_PORTS-1:0]        rsp_valid,
    input logic [DATA_W*NUM_PORTS-1:0] rsp_data,
    input logic [DATA_W*NUM_REGS-1:0]  reg_flat
);
    logic                 armed;
    logic [NUM_PORTS-1:0] took;
    logic [NUM_PORTS-1:0] rd_p;
    logic [NUM_PORTS-1:0] first_add;
    logic [NUM_REGS-1:0]  set_hit;
    logic [NUM_REGS-1:0]  add_hit;
    logic [DATA_W-1:0]    add_sum   [NUM_REGS];
    logic [DATA_W-1:0]    set_first [NUM_REGS];
    logic [DATA_W-1:0]    old_sel   [NUM_PORTS];

    // Enable checks one cycle after reset releases
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Per-register request summaries and per-port classifications
    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            set_hit[r]   = 1'b0;
            add_hit[r]   = 1'b0;
            add_sum[r]   = '0;
            set_first[r] = '0;
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            took[p]      = req_valid[p] && (req_op[2*p +: 2] != 2'b11);
            rd_p[p]      = req_valid[p] && (req_op[2*p +: 2] == 2'b00);
            first_add[p] = 1'b0;
            old_sel[p]   = reg_flat[DATA_W*req_idx[IDX_W*p +: IDX_W] +: DATA_W];
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_valid[p] && req_op[2*p +: 2] == 2'b01) begin
                if (!set_hit[req_idx[IDX_W*p +: IDX_W]])
                    set_first[req_idx[IDX_W*p +: IDX_W]] = req_data[DATA_W*p +: DATA_W];
                set_hit[req_idx[IDX_W*p +: IDX_W]] = 1'b1;
            end
            if (req_valid[p] && req_op[2*p +: 2] == 2'b10) begin
                first_add[p] = !add_hit[req_idx[IDX_W*p +: IDX_W]];
                add_hit[req_idx[IDX_W*p +: IDX_W]] = 1'b1;
                add_sum[req_idx[IDX_W*p +: IDX_W]] =
                    add_sum[req_idx[IDX_W*p +: IDX_W]] + req_data[DATA_W*p +: DATA_W];
            end
        end
    end

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        1'b1 |=> rsp_valid == $past(took)); // R3

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
        AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            rd_p[p] |=> rsp_data[DATA_W*p +: DATA_W] == $past(old_sel[p])); // R4
        AST_FIRST_ADD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            (first_add[p] && !set_hit[req_idx[IDX_W*p +: IDX_W]])
            |=> rsp_data[DATA_W*p +: DATA_W] == $past(old_sel[p])); // R6
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg_chk
        AST_REG_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_hit[r] && add_hit[r])
            |=> reg_flat[DATA_W*r +: DATA_W] ==
                $past(reg_flat[DATA_W*r +: DATA_W]) + $past(add_sum[r])); // R5
        AST_SET_BASE: assert property (@(posedge clk) disable iff (!rst_n)
            set_hit[r]
            |=> reg_flat[DATA_W*r +: DATA_W] ==
                $past(set_first[r]) + $past(add_sum[r])); // R9
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_hit[r] && !add_hit[r])
            |=> $stable(reg_flat[DATA_W*r +: DATA_W])); // R2
    end

endmodule

bind psu_top psu_checker #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_REGS  (NUM_REGS),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
) u_psu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_idx   (req_idx),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .reg_flat  (reg_flat)
);

// File: tb/psu_top_tb_top.sv
// Bench for psu_top: directed corner cycles plus seeded random traffic,
// checked against a behavioural model of the register file.
module psu_top_tb_top;
    localparam int P  = 8;
    localparam int R  = 8;
    localparam int W  = 32;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [P-1:0]    req_valid;
    logic [2*P-1:0]  req_op;
    logic [IW*P-1:0] req_idx;
    logic [W*P-1:0]  req_data;
    logic [P-1:0]    rsp_valid;
    logic [W*P-1:0]  rsp_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] model [R];
    logic         s_v   [P];
    logic [1:0]   s_op  [P];
    logic [IW-1:0] s_idx [P];
    logic [W-1:0] s_dat [P];
    logic         e_v   [P];
    logic [W-1:0] e_dat [P];

    always #10 clk = ~clk;

    psu_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .req_data  (req_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    task automatic clear_stim();
        for (int p = 0; p < P; p++) begin
            s_v[p] = 1'b0; s_op[p] = 2'b00; s_idx[p] = '0; s_dat[p] = '0;
        end
    endtask

    // Model: sets first (lowest port wins), then adds in port order
    task automatic predict();
        logic [W-1:0] run;
        logic         got_set;
        for (int p = 0; p < P; p++) begin
            e_v[p]   = s_v[p] && (s_op[p] != 2'b11);
            e_dat[p] = model[s_idx[p]];
        end
        for (int r = 0; r < R; r++) begin
            run = model[r];
            got_set = 1'b0;
            for (int p = 0; p < P; p++)
                if (s_v[p] && s_op[p] == 2'b01 && s_idx[p] == IW'(r) && !got_set) begin
                    run = s_dat[p];
                    got_set = 1'b1;
                end
            for (int p = 0; p < P; p++)
                if (s_v[p] && s_op[p] == 2'b10 && s_idx[p] == IW'(r)) begin
                    e_dat[p] = run;
                    run = run + s_dat[p];
                end
            model[r] = run;
        end
    endtask

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp, int port);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %0d: actual %h expected %h", tag, port, act, exp);
        end
    endtask

    // Drive one cycle of requests at a falling edge, check one cycle later
    task automatic apply(string tag);
        predict();
        for (int p = 0; p < P; p++) begin
            req_valid[p]         = s_v[p];
            req_op[2*p +: 2]     = s_op[p];
            req_idx[IW*p +: IW]  = s_idx[p];
            req_data[W*p +: W]   = s_dat[p];
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        for (int p = 0; p < P; p++) begin
            check({tag, " (R3 valid)"}, W'(rsp_valid[p]), W'(e_v[p]), p);
            if (e_v[p]) check(tag, rsp_data[W*p +: W], e_dat[p], p);
        end
        clear_stim();
    endtask

    // Read every register through ports 0..7
    task automatic read_all(string tag);
        clear_stim();
        for (int p = 0; p < P; p++) begin
            s_v[p] = 1'b1; s_op[p] = 2'b00; s_idx[p] = IW'(p);
        end
        apply(tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 1'b0; req_valid = '0; req_op = '0; req_idx = '0; req_data = '0;
        for (int r = 0; r < R; r++) model[r] = '0;
        clear_stim();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int p = 0; p < P; p++) check("R1 rsp_valid", W'(rsp_valid[p]), '0, p);
        read_all("R1");

        // R5: single add
        s_v[0] = 1; s_op[0] = 2'b10; s_idx[0] = 3'd2; s_dat[0] = 32'd7;
        apply("R5");
        s_v[3] = 1; s_op[3] = 2'b10; s_idx[3] = 3'd2; s_dat[3] = 32'd5;
        apply("R5");

        // R11: all ports add 1 to register 4
        for (int p = 0; p < P; p++) begin
            s_v[p] = 1; s_op[p] = 2'b10; s_idx[p] = 3'd4; s_dat[p] = 32'd1;
        end
        apply("R11");

        // R6: mixed increments, sparse ports on one register
        s_v[1] = 1; s_op[1] = 2'b10; s_idx[1] = 3'd4; s_dat[1] = 32'd100;
        s_v[5] = 1; s_op[5] = 2'b10; s_idx[5] = 3'd4; s_dat[5] = 32'd20;
        s_v[6] = 1; s_op[6] = 2'b10; s_idx[6] = 3'd4; s_dat[6] = 32'd3;
        s_v[7] = 1; s_op[7] = 2'b00; s_idx[7] = 3'd4;
        apply("R6");

        // R7: independent registers in one cycle
        for (int p = 0; p < P; p++) begin
            s_v[p] = 1; s_op[p] = 2'b10; s_idx[p] = IW'(p); s_dat[p] = 32'(p * 11 + 1);
        end
        apply("R7");
        read_all("R7");

        // R8: multiple sets, lowest port wins
        s_v[2] = 1; s_op[2] = 2'b01; s_idx[2] = 3'd6; s_dat[2] = 32'hAAAA_0001;
        s_v[4] = 1; s_op[4] = 2'b01; s_idx[4] = 3'd6; s_dat[4] = 32'hBBBB_0002;
        apply("R8");
        read_all("R8");

        // R9: set plus adds to the same register
        s_v[0] = 1; s_op[0] = 2'b10; s_idx[0] = 3'd1; s_dat[0] = 32'd4;
        s_v[3] = 1; s_op[3] = 2'b01; s_idx[3] = 3'd1; s_dat[3] = 32'd1000;
        s_v[5] = 1; s_op[5] = 2'b10; s_idx[5] = 3'd1; s_dat[5] = 32'd6;
        apply("R9");
        read_all("R9");

        // R10: wrap modulo 2^32
        s_v[0] = 1; s_op[0] = 2'b01; s_idx[0] = 3'd3; s_dat[0] = 32'hFFFF_FFFE;
        s_v[1] = 1; s_op[1] = 2'b10; s_idx[1] = 3'd3; s_dat[1] = 32'd1;
        s_v[2] = 1; s_op[2] = 2'b10; s_idx[2] = 3'd3; s_dat[2] = 32'd5;
        s_v[3] = 1; s_op[3] = 2'b10; s_idx[3] = 3'd3; s_dat[3] = 32'd2;
        apply("R10");
        read_all("R10");

        // R2: reserved code ignored, then state confirmed by reads
        for (int p = 0; p < P; p++) begin
            s_v[p] = 1; s_op[p] = 2'b11; s_idx[p] = IW'(p); s_dat[p] = 32'hDEAD_BEEF;
        end
        apply("R2");
        read_all("R2");

        // R4: read alongside a set and add to the same register
        s_v[0] = 1; s_op[0] = 2'b01; s_idx[0] = 3'd5; s_dat[0] = 32'd9;
        s_v[1] = 1; s_op[1] = 2'b00; s_idx[1] = 3'd5;
        s_v[2] = 1; s_op[2] = 2'b10; s_idx[2] = 3'd5; s_dat[2] = 32'd2;
        apply("R4");

        // Random collisions on three registers with mixed codes
        for (int c = 0; c < 300; c++) begin
            for (int p = 0; p < P; p++) begin
                s_v[p]   = ($urandom % 4) != 0;
                s_op[p]  = 2'($urandom % 4);
                s_idx[p] = IW'($urandom % 3);
                s_dat[p] = ($urandom % 2) ? $urandom : 32'($urandom % 8);
            end
            apply("R6 random");
        end
        read_all("R6 final");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule